// File: doc/BRIEF.md
# Debug Register Target with Interlocked Request/Acknowledge

This block is a small register target for a debug path. A master starts each access by raising a request together with a direction bit, an address and write data. The target takes them on the first clock edge where the request is high while its acknowledge is low. On that same edge it performs the access and raises its acknowledge. It holds the acknowledge and the returned data steady until the master lowers the request. The acknowledge then falls on the next edge, which completes a full four-phase exchange.

The register map has three kinds of entry. A writable control word resets to the value 4, which encodes a terminated state. A read-only machine-state word always reads back the test constant 0xDEADBEEF. Every other address is acknowledged without effect. A write to the control word reports the contents that word held before the write. The master can therefore swap a value in a single exchange.

Top module: `dbg_reg_target`

## Requirements
- R1: Synchronous active-high reset forces `ack` low and returns the control word to 4, including a reset that arrives in the middle of an exchange.
- R2: When `req` is sampled high while `ack` is low, `ack` is high after that same clock edge. `ack` never rises while `req` is low.
- R3: Once high, `ack` remains high on every edge at which `req` is still sampled high.
- R4: On the first edge at which `req` is sampled low while `ack` is high, `ack` falls.
- R5: `rdata` does not change while `ack` is high.
- R6: A write (`we`=1) to the control address `CTRL_ADDR` (default 0x00) loads all 64 bits of `wdata` into the control word. A later read of that address returns the new value.
- R7: A write to the control address returns the control word's previous contents on `rdata`.
- R8: A read (`we`=0) of the machine-state address `MSTATE_ADDR` (default 0x01) returns 0x00000000DEADBEEF.
- R9: A write to the machine-state address or to any unmapped address is acknowledged and changes neither the control word nor the machine-state value.
- R10: A read or write of an unmapped address returns zero on `rdata`, and so does a write to the machine-state address.
- R11: A new request raised one clock after `ack` is seen low is accepted normally.
- R12: Changes to `addr`, `we` and `wdata` after the accepting edge do not affect the exchange in progress or the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request from master |
| we | input | 1 | 1 = write, 0 = read; sampled when the request is accepted |
| addr | input | ADDR_W (8) | Register address, sampled when the request is accepted |
| wdata | input | DATA_W (64) | Write data, sampled when the request is accepted |
| rdata | output | DATA_W (64) | Returned data, held while `ack` is high |
| ack | output | 1 | Acknowledge to master |

## Verification
A write to the control word updates the word and captures its old contents for `rdata` on the same edge. The bench provokes this by writing a known value over the reset value and then over a full-width 64-bit pattern. It expects `rdata` to show the previous contents and a following read to show the new ones. The bench also changes the address and write data in the first held cycle of every exchange. It then confirms that neither the held response nor any later read reflects the change.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;

    // Which register an accepted access hits
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_MSTATE = 2'd2
    } sel_e;

    // Handshake tracker state
    typedef struct packed {
        logic ack;
    } hs_state_t;

endpackage

// File: rtl/dbgt_handshake.sv
module dbgt_handshake
    import dbgt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic take,
    output logic ack
);

    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = req && !st_q.ack;
        if (take) begin
            st_d.ack = 1'b1;
        end else if (st_q.ack && !req) begin
            st_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack = st_q.ack;

endmodule

// File: rtl/dbgt_decode.sv
module dbgt_decode
    import dbgt_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h00,
    parameter logic [ADDR_W-1:0] MSTATE_ADDR = 'h01
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    always_comb begin
        if (addr == CTRL_ADDR) begin
            sel = SEL_CTRL;
        end else if (addr == MSTATE_ADDR) begin
            sel = SEL_MSTATE;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/dbgt_regs.sv
module dbgt_regs
    import dbgt_pkg::*;
#(
    parameter int                DATA_W     = 64,
    parameter logic [DATA_W-1:0] CTRL_RST   = 'h4,
    parameter logic [DATA_W-1:0] MSTATE_VAL = 'hDEADBEEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              we,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            unique case (sel)
                SEL_CTRL: begin
                    // old contents go back, new contents land, same edge
                    st_d.rdata = st_q.ctrl;
                    if (we) begin
                        st_d.ctrl = wdata;
                    end
                end
                SEL_MSTATE: begin
                    st_d.rdata = we ? '0 : MSTATE_VAL;
                end
                default: begin
                    st_d.rdata = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ctrl  <= CTRL_RST;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target
    import dbgt_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 64,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h00,
    parameter logic [ADDR_W-1:0] MSTATE_ADDR = 'h01,
    parameter logic [DATA_W-1:0] CTRL_RST    = 'h4,
    parameter logic [DATA_W-1:0] MSTATE_VAL  = 'hDEADBEEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);

    logic take;
    sel_e sel;

    dbgt_handshake u_hs (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .take (take),
        .ack  (ack)
    );

    dbgt_decode #(
        .ADDR_W      (ADDR_W),
        .CTRL_ADDR   (CTRL_ADDR),
        .MSTATE_ADDR (MSTATE_ADDR)
    ) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    dbgt_regs #(
        .DATA_W     (DATA_W),
        .CTRL_RST   (CTRL_RST),
        .MSTATE_VAL (MSTATE_VAL)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .we    (we),
        .sel   (sel),
        .wdata (wdata),
        .rdata (rdata)
    );

endmodule

// File: rtl/dbgt_checker.sv
module dbgt_checker #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 64,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h00,
    parameter logic [ADDR_W-1:0] MSTATE_ADDR = 'h01,
    parameter logic [DATA_W-1:0] MSTATE_VAL  = 'hDEADBEEF
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              ack
);

    a_r2_ack_rises: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> ack);

    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        (!req && !ack) |=> !ack);

    a_r3_ack_held: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> ack);

    a_r4_ack_falls: assert property (@(posedge clk) disable iff (rst)
        (ack && !req) |=> !ack);

    a_r5_rdata_stable: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> $stable(rdata));

    a_r8_mstate_value: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && !we && addr == MSTATE_ADDR) |=> (rdata == MSTATE_VAL));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && addr != CTRL_ADDR && addr != MSTATE_ADDR) |=> (rdata == '0));

endmodule

bind dbg_reg_target dbgt_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CTRL_ADDR   (CTRL_ADDR),
    .MSTATE_ADDR (MSTATE_ADDR),
    .MSTATE_VAL  (MSTATE_VAL)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .we    (we),
    .addr  (addr),
    .rdata (rdata),
    .ack   (ack)
);

// File: tb/dbg_reg_target_tb.sv
`timescale 1ns/1ps
module dbg_reg_target_tb;

    localparam logic [7:0]  A_CTRL   = 8'h00;
    localparam logic [7:0]  A_MSTATE = 8'h01;
    localparam logic [63:0] MSTATE   = 64'h0000_0000_DEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [7:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        ack;

    int n_run  = 0;
    int n_fail = 0;
    logic [63:0] model_ctrl = 64'h4;

    always #2.5 clk = ~clk;

    dbg_reg_target u_dut (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .we    (we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ack   (ack)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One complete exchange; called at a negedge, returns at a negedge
    // one clock after ack was seen low (minimum gap for the next request).
    task automatic xfer(input logic w, input logic [7:0] a, input logic [63:0] d,
                        input int hold, input logic [63:0] exp_rd, input string tag);
        check(ack == 1'b0, {tag, " R2 ack low before req"}, 64'(ack), 64'd0);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        check(ack == 1'b1, {tag, " R2 R11 ack after accept"}, 64'(ack), 64'd1);
        check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
        for (int i = 0; i < hold; i++) begin
            if (i == 0) begin
                // R12: disturb the captured inputs
                we = ~w; addr = ~a; wdata = ~d;
            end
            @(negedge clk);
            check(ack == 1'b1, {tag, " R3 ack held"}, 64'(ack), 64'd1);
            check(rdata == exp_rd, {tag, " R5 R12 rdata stable"}, rdata, exp_rd);
        end
        req = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, {tag, " R4 ack drop"}, 64'(ack), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(ack == 1'b0, "R1 ack in reset", 64'(ack), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        xfer(1'b0, A_CTRL, '0, 1, 64'h4, "R1 ctrl reset value");
    endtask

    task automatic t_mstate;
        xfer(1'b0, A_MSTATE, '0, 2, MSTATE, "R8 mstate read");
    endtask

    task automatic t_ctrl_write;
        xfer(1'b1, A_CTRL, 64'h5, 1, model_ctrl, "R7 old value on write");
        model_ctrl = 64'h5;
        xfer(1'b0, A_CTRL, '0, 1, model_ctrl, "R6 readback");
        xfer(1'b1, A_CTRL, 64'hA5A5_0123_4567_89EF, 3, model_ctrl, "R7 old value wide");
        model_ctrl = 64'hA5A5_0123_4567_89EF;
        xfer(1'b0, A_CTRL, '0, 0, model_ctrl, "R6 wide readback");
    endtask

    task automatic t_no_effect;
        xfer(1'b1, A_MSTATE, 64'h1111, 1, 64'd0, "R9 R10 write mstate");
        xfer(1'b1, 8'h77, 64'h2222, 1, 64'd0, "R9 R10 write unmapped");
        xfer(1'b0, A_CTRL, '0, 1, model_ctrl, "R9 ctrl unchanged");
        xfer(1'b0, A_MSTATE, '0, 1, MSTATE, "R9 mstate unchanged");
        xfer(1'b0, 8'hFE, '0, 2, 64'd0, "R10 unmapped read");
    endtask

    task automatic t_back_to_back;
        // R11: minimum gap between consecutive exchanges
        xfer(1'b0, A_MSTATE, '0, 0, MSTATE, "R11 first");
        xfer(1'b0, A_CTRL, '0, 0, model_ctrl, "R11 second");
        xfer(1'b0, 8'h42, '0, 0, 64'd0, "R11 third");
    endtask

    task automatic t_reset_mid;
        req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = 64'h9;
        @(posedge clk); @(negedge clk);
        model_ctrl = 64'h9;
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R1 ack cleared mid exchange", 64'(ack), 64'd0);
        rst = 1'b0;
        model_ctrl = 64'h4;
        @(negedge clk);
        xfer(1'b0, A_CTRL, '0, 1, model_ctrl, "R1 ctrl after mid reset");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mstate();
        t_ctrl_write();
        t_no_effect();
        t_back_to_back();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule